// File: doc/BRIEF.md
# Clock Source Selection Controller

This block chooses which of seven oscillator sources drives the system clock. Software reaches it through a small register port: it turns sources on, reads their ready flags, sets the PLL multiplier and selects the active source. The block drives a mux select code and a set of oscillator enables. Oscillators are outside the block. They answer on ready inputs, and the two crystal sources also supply an activity line that changes level while the crystal is running.

Changing the selected source or the PLL multiplier needs a short unlock sequence. Software first writes a fixed signature to the key register, then does the protected write within a four-cycle window. The block never selects a source that is not ready, and it never turns off the source currently in use. A crystal that is selected but stops showing activity for a programmable number of cycles is dropped. The block falls back to the 2 MHz internal RC source, and one cycle later a sticky failure interrupt is raised. Software clears that interrupt by writing 1 to it.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset the select code is 0 (2 MHz internal RC), the enable vector is 7'b0000001, the PLL multiplier reads 2, the idle limit reads 16 and the failure interrupt is low.
- R2: The source codes are: 0 RC 2 MHz, 1 internal 32 MHz, 2 RC 32.768 kHz, 3 crystal 0.4–20 MHz, 4 crystal 32.768 kHz, 5 external clock, 6 PLL. A select write of code 7 is ignored.
- R3: The register map is: address 0 key, 1 select (bits 2:0), 2 enable (bits 6:0, bit n controls source n, driven on `osc_en`), 3 ready (bit n is `osc_rdy[n]`, read only), 4 failure flag (bit 0), 5 PLL multiplier (bits 4:0), 6 idle limit (8 bits). Reads are combinational from `reg_addr`.
- R4: A write to select or PLL takes effect only if the key register received 8'h9D in one of the four cycles before it. A protected write in the first through fourth cycle after the key cycle is accepted, and one in the fifth or later cycle is ignored.
- R5: A key write with any value other than 8'h9D opens no window, and it also closes a window that is already open. Any protected write closes the window, so a second protected write needs a new key.
- R6: A select write that names a source whose ready input is low is ignored, and the current selection stays.
- R7: An enable write cannot clear the bit of the currently selected source. That bit stays 1 and the other bits take the written value.
- R8: The PLL multiplier accepts values 2 to 31. Values outside that range are ignored, even when the write is unlocked.
- R9: A write of 0 to the idle limit is ignored. While crystal 3 or 4 is selected, the block counts cycles since its activity input last changed, and selection itself counts as a change. If the input holds steady for LIMIT full cycles, the select code becomes 0 at the end of the next cycle, and `fail_irq` rises one cycle after that. A fallback also sets enable bit 0.
- R10: `fail_irq` stays high until bit 0 of address 4 is written with 1. Writing 0 there has no effect.
- R11: When a fallback and an accepted protected select write occur in the same cycle, the fallback wins and the select code becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference/bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| osc_rdy | input | 7 | Ready flag from each source |
| xtal_act | input | 2 | Activity lines of crystal 3 (bit 0) and crystal 4 (bit 1) |
| osc_en | output | 7 | Enable to each source |
| clk_sel | output | 3 | System clock mux select code |
| pll_mult | output | 5 | PLL multiplication factor |
| fail_irq | output | 1 | Sticky crystal failure interrupt |

## Verification
A crystal failure and a software select write can land in the same cycle. Because of the R9 timing rule, the fallback cycle is known exactly. The bench selects the 32.768 kHz crystal, keeps its activity line still, and times a key write and a select-to-PLL write so that the select write falls in that fallback cycle. The case passes when the select code reads 0 instead of 6, and `fail_irq` then rises on the following cycle.

// File: rtl/clksel_pkg.sv
// Package: shared constants for the clock source selection controller.
// Assumes seven sources, two of which are crystals with activity monitors.
package clksel_pkg;
    localparam int NUM_SRC  = 7;
    localparam int SEL_W    = 3;
    localparam int NUM_XTAL = 2;

    // Source codes; the mux outside decodes these values.
    localparam logic [SEL_W-1:0] SRC_RC2M   = 3'd0;
    localparam logic [SEL_W-1:0] SRC_RC32M  = 3'd1;
    localparam logic [SEL_W-1:0] SRC_RC32K  = 3'd2;
    localparam logic [SEL_W-1:0] SRC_XTAL   = 3'd3;
    localparam logic [SEL_W-1:0] SRC_XTAL32 = 3'd4;
    localparam logic [SEL_W-1:0] SRC_EXT    = 3'd5;
    localparam logic [SEL_W-1:0] SRC_PLL    = 3'd6;

    // Register addresses.
    localparam logic [2:0] A_KEY  = 3'd0;
    localparam logic [2:0] A_SEL  = 3'd1;
    localparam logic [2:0] A_EN   = 3'd2;
    localparam logic [2:0] A_RDY  = 3'd3;
    localparam logic [2:0] A_FAIL = 3'd4;
    localparam logic [2:0] A_PLL  = 3'd5;
    localparam logic [2:0] A_LIM  = 3'd6;

    localparam logic [7:0] KEY_SIG = 8'h9D;

    // Which source code each crystal monitor watches.
    function automatic logic [SEL_W-1:0] xtal_code(input int idx);
        return (idx == 0) ? SRC_XTAL : SRC_XTAL32;
    endfunction
endpackage

// File: rtl/clksel_key_guard.sv
// Module: timed unlock window for protected registers.
// Opens for WIN cycles after a correct key write; closes on any protected
// write, on a wrong key, or when the window runs out.
module clksel_key_guard #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_ok,
    input  logic key_bad,
    input  logic prot_wr,
    output logic unlocked
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] win_cnt;

    // Window counter: load on a good key, clear on use or a bad key, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (key_ok)
            win_cnt <= CW'(WIN);
        else if (key_bad || prot_wr)
            win_cnt <= '0;
        else if (win_cnt != '0)
            win_cnt <= win_cnt - 1'b1;
    end

    assign unlocked = (win_cnt != '0);

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= CW'(WIN)); // R4
    AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !key_ok) |=> !unlocked); // R5
    AST_BAD_KEY_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> !unlocked); // R5
endmodule

// File: rtl/clksel_fail_mon.sv
// Module: crystal activity monitor.
// Counts cycles since the activity line last changed while the crystal is
// watched (selected); flags failure once the count reaches the limit.
// Assumes the activity line is already in the clk domain and limit >= 1.
module clksel_fail_mon #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             watch,
    input  logic             act,
    input  logic [CNT_W-1:0] limit,
    output logic             fail
);
    logic             act_q;
    logic [CNT_W-1:0] idle_cnt;
    logic             act_chg;

    assign act_chg = act ^ act_q;

    // Idle counter: cleared by activity or when not watched, saturates at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            idle_cnt <= '0;
        end else begin
            act_q <= act;
            if (!watch || act_chg)
                idle_cnt <= '0;
            else if (idle_cnt != '1)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign fail = watch && (idle_cnt >= limit);

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (watch && act_chg) |=> (idle_cnt == '0)); // R9
endmodule

// File: rtl/clksel_ctrl.sv
// Module: clock source selection controller (top).
// Holds the enable, select, PLL and idle-limit registers, guards select and
// PLL with the key window, and forces a fallback to the 2 MHz RC source when
// a selected crystal goes quiet. Assumes osc_rdy and xtal_act are synchronous
// to clk and that reset is held for at least two cycles.
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int         WIN_CYC = 4,
    parameter int         LIM_W   = 8,
    parameter int         LIM_RST = 16,
    parameter int         PLL_W   = 5,
    parameter int         PLL_MIN = 2,
    parameter int         PLL_MAX = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic [NUM_SRC-1:0]   osc_rdy,
    input  logic [NUM_XTAL-1:0]  xtal_act,
    output logic [NUM_SRC-1:0]   osc_en,
    output logic [SEL_W-1:0]     clk_sel,
    output logic [PLL_W-1:0]     pll_mult,
    output logic                 fail_irq
);
    logic                wr_key, key_ok, key_bad, wr_sel, wr_pll, prot_wr;
    logic                unlocked;
    logic                sel_ok, pll_ok;
    logic [SEL_W-1:0]    sel_req;
    logic [NUM_XTAL-1:0] xtal_fail;
    logic                fail_any;
    logic                fail_pend;
    logic [LIM_W-1:0]    idle_lim;
    logic [NUM_SRC-1:0]  sel_onehot;
    logic [NUM_SRC-1:0]  en_next;

    // Decode of register writes.
    always_comb begin
        wr_key  = reg_we && (reg_addr == A_KEY);
        key_ok  = wr_key && (reg_wdata == KEY_SIG);
        key_bad = wr_key && (reg_wdata != KEY_SIG);
        wr_sel  = reg_we && (reg_addr == A_SEL);
        wr_pll  = reg_we && (reg_addr == A_PLL);
        prot_wr = wr_sel || wr_pll;
        sel_req = reg_wdata[SEL_W-1:0];
        sel_ok  = wr_sel && unlocked && (int'(sel_req) < NUM_SRC) && osc_rdy[sel_req];
        pll_ok  = wr_pll && unlocked
                  && (int'(reg_wdata) >= PLL_MIN) && (int'(reg_wdata) <= PLL_MAX);
    end

    clksel_key_guard #(.WIN(WIN_CYC)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_ok   (key_ok),
        .key_bad  (key_bad),
        .prot_wr  (prot_wr),
        .unlocked (unlocked)
    );

    // One activity monitor per crystal source.
    for (genvar g = 0; g < NUM_XTAL; g++) begin : g_mon
        clksel_fail_mon #(.CNT_W(LIM_W)) u_mon (
            .clk   (clk),
            .rst_n (rst_n),
            .watch (clk_sel == xtal_code(g)),
            .act   (xtal_act[g]),
            .limit (idle_lim),
            .fail  (xtal_fail[g])
        );
    end

    assign fail_any = |xtal_fail;

    // Select register: fallback has priority over an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_sel <= SRC_RC2M;
        else if (fail_any)
            clk_sel <= SRC_RC2M;
        else if (sel_ok)
            clk_sel <= sel_req;
    end

    // Next enable vector: selected source is kept, fallback source is forced on.
    always_comb begin
        sel_onehot = '0;
        sel_onehot[clk_sel] = 1'b1;
        en_next = osc_en;
        if (reg_we && (reg_addr == A_EN))
            en_next = reg_wdata[NUM_SRC-1:0] | sel_onehot;
        if (fail_any)
            en_next[SRC_RC2M] = 1'b1;
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            osc_en <= NUM_SRC'(1);
        else
            osc_en <= en_next;
    end

    // PLL multiplier register, protected and range checked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pll_mult <= PLL_W'(PLL_MIN);
        else if (pll_ok)
            pll_mult <= reg_wdata[PLL_W-1:0];
    end

    // Idle limit register; zero is rejected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_lim <= LIM_W'(LIM_RST);
        else if (reg_we && (reg_addr == A_LIM) && (reg_wdata[LIM_W-1:0] != '0))
            idle_lim <= reg_wdata[LIM_W-1:0];
    end

    // Failure flag: raised one cycle after the fallback, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_pend <= 1'b0;
            fail_irq  <= 1'b0;
        end else begin
            fail_pend <= fail_any;
            if (fail_pend)
                fail_irq <= 1'b1;
            else if (reg_we && (reg_addr == A_FAIL) && reg_wdata[0])
                fail_irq <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SEL:  reg_rdata = 8'(clk_sel);
            A_EN:   reg_rdata = 8'(osc_en);
            A_RDY:  reg_rdata = 8'(osc_rdy);
            A_FAIL: reg_rdata = 8'(fail_irq);
            A_PLL:  reg_rdata = 8'(pll_mult);
            A_LIM:  reg_rdata = 8'(idle_lim);
            default: reg_rdata = '0;
        endcase
    end

    AST_SEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(clk_sel) < NUM_SRC); // R2
    AST_SEL_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != $past(clk_sel) && clk_sel != SRC_RC2M) |-> $past(unlocked)); // R4
    AST_SEL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != $past(clk_sel) && clk_sel != SRC_RC2M)
        |-> (($past(osc_rdy) >> clk_sel) & NUM_SRC'(1)) != '0); // R6
    AST_SELECTED_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en[clk_sel]); // R7
    AST_PLL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pll_mult) >= PLL_MIN) && (int'(pll_mult) <= PLL_MAX)); // R8
    AST_IRQ_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_irq) |-> ($past(clk_sel) == SRC_RC2M)); // R9
    AST_FALLBACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fail_any |=> (clk_sel == SRC_RC2M)); // R11
endmodule

// File: tb/sim_clksel_ctrl.sv
// Bench for clksel_ctrl: vector table for select writes, then directed cases.
module sim_clksel_ctrl;
    localparam logic [2:0] KA = 3'd0, SA = 3'd1, EA = 3'd2, RA = 3'd3,
                           FA = 3'd4, PA = 3'd5, LA = 3'd6;
    localparam logic [7:0] KEY = 8'h9D;
    localparam int LIM = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] osc_rdy;
    logic [1:0] xtal_act = '0;
    logic [6:0] osc_en;
    logic [2:0] clk_sel;
    logic [4:0] pll_mult;
    logic       fail_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clksel_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .osc_rdy(osc_rdy),
        .xtal_act(xtal_act), .osc_en(osc_en), .clk_sel(clk_sel),
        .pll_mult(pll_mult), .fail_irq(fail_irq)
    );

    // Oscillator model: ready comes 2+i cycles after enable.
    logic [3:0] rcnt [7];
    always_ff @(posedge clk) begin
        for (int i = 0; i < 7; i++) begin
            if (!osc_en[i]) rcnt[i] <= '0;
            else if (rcnt[i] != 4'hF) rcnt[i] <= rcnt[i] + 1'b1;
        end
    end
    always_comb begin
        for (int i = 0; i < 7; i++)
            osc_rdy[i] = osc_en[i] && (int'(rcnt[i]) >= 2 + i);
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Callers stand at a negedge; each write occupies one cycle.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    // {use_key, gap[2:0], sel[2:0], expected[2:0]}
    localparam logic [9:0] VEC [9] = '{
        {1'b1, 3'd0, 3'd1, 3'd1},
        {1'b0, 3'd0, 3'd2, 3'd1},
        {1'b1, 3'd3, 3'd2, 3'd2},
        {1'b1, 3'd4, 3'd6, 3'd2},
        {1'b1, 3'd0, 3'd5, 3'd2},
        {1'b1, 3'd0, 3'd7, 3'd2},
        {1'b1, 3'd0, 3'd0, 3'd0},
        {1'b1, 3'd0, 3'd6, 3'd6},
        {1'b1, 3'd1, 3'd0, 3'd0}
    };

    initial begin
        int v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 sel", int'(clk_sel), 0);
        chk("R1 en", int'(osc_en), 1);
        chk("R1 irq", int'(fail_irq), 0);
        rd(PA, v); chk("R1 pll", v, 2);
        rd(LA, v); chk("R1 lim", v, 16);

        // R3 enable sources 0-4 and 6, then read ready
        wr(EA, 8'h5F);
        idle(20);
        chk("R3 en out", int'(osc_en), 8'h5F);
        rd(RA, v); chk("R3 rdy read", v, 8'h5F);

        // Vector table: R2 R4 R6
        for (int k = 0; k < 9; k++) begin
            if (VEC[k][9]) wr(KA, KEY);
            idle(int'(VEC[k][8:6]));
            wr(SA, {5'd0, VEC[k][5:3]});
            chk("R4/R6/R2 vec sel", int'(clk_sel), int'(VEC[k][2:0]));
            rd(SA, v); chk("R3 sel read", v, int'(VEC[k][2:0]));
        end

        // R5 wrong key, single use, wrong key closes
        wr(KA, 8'h9C); wr(SA, 8'd1);
        chk("R5 bad key", int'(clk_sel), 0);
        wr(KA, KEY); wr(SA, 8'd1); wr(SA, 8'd2);
        chk("R5 one write", int'(clk_sel), 1);
        wr(KA, KEY); wr(KA, 8'h00); wr(SA, 8'd2);
        chk("R5 bad key closes", int'(clk_sel), 1);

        // R7 selected source keeps its enable
        wr(EA, 8'h00);
        chk("R7 en kept", int'(osc_en), 8'h02);
        wr(EA, 8'h5F); idle(20);
        wr(KA, KEY); wr(SA, 8'd0);

        // R8 PLL range and protection
        wr(KA, KEY); wr(PA, 8'd16); rd(PA, v); chk("R8 pll 16", v, 16);
        wr(KA, KEY); wr(PA, 8'd1);  rd(PA, v); chk("R8 pll 1", v, 16);
        wr(KA, KEY); wr(PA, 8'd32); rd(PA, v); chk("R8 pll 32", v, 16);
        wr(PA, 8'd5); chk("R8 pll no key", int'(pll_mult), 16);

        // R9 limit register
        wr(LA, 8'd0); rd(LA, v); chk("R9 lim zero", v, 16);
        wr(LA, 8'(LIM)); rd(LA, v); chk("R9 lim", v, LIM);

        // R9 activity keeps crystal selected
        wr(KA, KEY); wr(SA, 8'd3);
        for (int k = 0; k < 10; k++) begin
            xtal_act[0] = ~xtal_act[0];
            idle(4);
        end
        chk("R9 alive sel", int'(clk_sel), 3);
        chk("R9 alive irq", int'(fail_irq), 0);

        // R9 exact fallback timing
        wr(KA, KEY); wr(SA, 8'd0);
        wr(KA, KEY); wr(SA, 8'd3);
        for (int k = 0; k <= LIM; k++) begin
            chk("R9 held", int'(clk_sel), 3);
            idle(1);
        end
        chk("R9 fallback sel", int'(clk_sel), 0);
        chk("R9 irq after", int'(fail_irq), 0);
        chk("R9 en0", int'(osc_en[0]), 1);
        idle(1);
        chk("R9 irq", int'(fail_irq), 1);

        // R10 write-one-to-clear
        wr(FA, 8'd0); chk("R10 keep", int'(fail_irq), 1);
        wr(FA, 8'd1); chk("R10 clear", int'(fail_irq), 0);

        // R11 fallback coincides with accepted select write
        wr(KA, KEY); wr(SA, 8'd4);
        chk("R11 sel xtal32", int'(clk_sel), 4);
        idle(LIM - 1);
        wr(KA, KEY); wr(SA, 8'd6);
        chk("R11 fallback wins", int'(clk_sel), 0);
        idle(1);
        chk("R11 irq", int'(fail_irq), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule